// File: doc/BRIEF.md
# Pseudo-Random Correlation Response Analyzer

This block is on-chip self-test logic for an analog path that runs from a DAC through the circuit under test and back through an ADC. It produces a white-noise-like digital stimulus from a maximal-length shift register. Each stimulus bit becomes a sample of plus or minus full scale, and this sample stream is what the DAC plays. The samples that return from the ADC are multiplied and summed over a window of 2^K accepted samples. The window sum is then divided by the window length with an arithmetic shift.

In cross mode, each returned sample is multiplied by the stimulus sample from m steps earlier, so the block estimates the lag-m cross-correlation between stimulus and response. A sweep of m over several sessions traces the impulse response of the path. In auto mode, each returned sample is multiplied by itself, which gives the mean power of the response. A single start pulse captures the configuration and clears the block. Done rises when the window fills, and the result then stays fixed until the next start.

Top module: `prcorr_analyzer`

## Requirements
- R1: After reset, busy and done are low and result is zero.
- R2: The stimulus bit is bit 0 of a 16-bit state. Each step shifts the state right by one; when the old bit 0 was 1, the new state is XORed with mask 0xB400. A start loads the seed, or 0x0001 when the seed is zero. The state steps once per accepted sample and never otherwise.
- R3: stim_out is +(2^(SAMPLE_W-1)-1) when the stimulus bit is 1 and -(2^(SAMPLE_W-1)-1) when it is 0. With the defaults these values are +2047 and -2047.
- R4: With mode=0 (cross), accepted sample number n of the window (counting from 0) adds y[n]*x[n-m] to the sum, where x[k] is the stim_out value at the time of sample k and m is the lag (0..63). Terms with n<m add zero.
- R5: With mode=1 (auto), each accepted sample adds y[n]*y[n] to the sum.
- R6: A window holds 2^K accepted samples, with K from win_log (0..15). The result is the exact window sum shifted right arithmetically by K, which floors the quotient.
- R7: A sample counts only when samp_valid is high while busy and start is low. Cycles without an accepted sample leave the stimulus, the count and the sum unchanged.
- R8: Done rises, and busy falls, in the cycle after the clock edge that accepts the last sample of the window. While done is high, result and stim_out stay constant and incoming samples have no effect.
- R9: A start pulse at any time (including in the middle of a window) captures mode, lag, win_log and seed, clears the sum, the count and the lag history, lowers done and raises busy on the next edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins a new window |
| mode | input | 1 | 0 cross-correlation, 1 auto-correlation; captured at start |
| lag | input | 6 | Stimulus delay m in samples; captured at start |
| win_log | input | 4 | K, window of 2^K samples; captured at start |
| seed | input | 16 | Shift register seed; captured at start |
| stim_out | output | 12 | Signed stimulus sample for the DAC |
| samp_in | input | 12 | Signed returned ADC sample |
| samp_valid | input | 1 | samp_in holds a new sample |
| busy | output | 1 | A window is being collected |
| done | output | 1 | Window complete, result valid |
| result | output | 24 | Signed average of the products |

## Verification
The assertions rely on three things about the inputs. Reset is applied before the first active clock edge. samp_in carries a defined value in every cycle that samp_valid is high. lag, seed, mode and win_log matter only in the start cycle, so they may change freely at other times. The bench resets before any start and drives every input on the falling clock edge. It keeps samp_valid low in the start cycle, except in the case where it deliberately restarts a window in the middle. It builds each response sample from its own model of the stimulus.

// File: rtl/prc_pkg.sv
package prc_pkg;
  localparam int LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hB400;
  localparam logic [LFSR_W-1:0] LFSR_ONE  = 16'h0001;

  typedef enum logic {MODE_CROSS = 1'b0, MODE_AUTO = 1'b1} corr_mode_e;

  // Galois right-shift step of the maximal-length polynomial
  function automatic logic [LFSR_W-1:0] lfsr_next(input logic [LFSR_W-1:0] s);
    return (s >> 1) ^ (s[0] ? LFSR_MASK : '0);
  endfunction

  // An all-zero seed would lock the register; substitute one
  function automatic logic [LFSR_W-1:0] seed_fix(input logic [LFSR_W-1:0] s);
    return (s == '0) ? LFSR_ONE : s;
  endfunction
endpackage

// File: rtl/prc_lfsr.sv
module prc_lfsr
  import prc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [LFSR_W-1:0] seed,
  output logic              bit_o
);
  logic [LFSR_W-1:0] st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       st <= LFSR_ONE;
    else if (load)    st <= seed_fix(seed);
    else if (advance) st <= lfsr_next(st);
  end

  assign bit_o = st[0];

  // R2: the register never reaches the locked all-zero state
  a_r2_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    st != '0);
  // R7: without an accepted sample or start the stimulus holds
  a_r7_stim_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(st));
endmodule

// File: rtl/prc_lagline.sv
module prc_lagline #(
  parameter int DEPTH = 63,
  parameter int SEL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             shift,
  input  logic             din,
  input  logic [SEL_W-1:0] sel,
  output logic             tap
);
  logic [DEPTH-1:0] hist;
  logic [DEPTH:0]   taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     hist <= '0;
    else if (clear) hist <= '0;
    else if (shift) hist <= {hist[DEPTH-2:0], din};
  end

  // tap 0 is the current bit, tap i the bit i samples back
  assign taps[0] = din;
  for (genvar i = 1; i <= DEPTH; i++) begin : g_tap
    assign taps[i] = hist[i-1];
  end

  assign tap = taps[sel];

  // R4: newest history entry is the bit presented at the last shift
  a_r4_hist_shift: assert property (@(posedge clk) disable iff (!rst_n)
    (shift && !clear) |=> hist[0] == $past(din));
  // R9: clear empties the history
  a_r9_hist_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> hist == '0);
endmodule

// File: rtl/prc_mac.sv
module prc_mac #(
  parameter int PROD_W = 24,
  parameter int ACC_W  = 40,
  parameter int RES_W  = 24,
  parameter int K_W    = 4,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clear,
  input  logic                    accept,
  input  logic signed [PROD_W-1:0] prod,
  input  logic [K_W-1:0]          k,
  output logic [CNT_W-1:0]        cnt,
  output logic                    win_end,
  output logic signed [RES_W-1:0] result
);
  logic signed [ACC_W-1:0] acc, acc_sum, avg;
  logic [CNT_W-1:0]        win_last;

  assign win_last = (CNT_W'(1) << k) - CNT_W'(1);
  assign acc_sum  = acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
  assign avg      = acc_sum >>> k;
  assign win_end  = accept && (cnt == win_last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc    <= '0;
      cnt    <= '0;
      result <= '0;
    end else if (clear) begin
      acc <= '0;
      cnt <= '0;
    end else if (accept) begin
      acc <= acc_sum;
      cnt <= cnt + CNT_W'(1);
      if (win_end) result <= avg[RES_W-1:0];
    end
  end

  // R6: no sample is accepted beyond the window length
  a_r6_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> cnt <= win_last);
  // R9: start leaves the sum and count empty
  a_r9_mac_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc == '0) && (cnt == '0));
  // R8: result moves only at a window end
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !win_end |=> $stable(result));
endmodule

// File: rtl/prcorr_analyzer.sv
module prcorr_analyzer
  import prc_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int MAX_LAG  = 63,
  parameter int K_MAX    = 15,
  localparam int LAG_W   = $clog2(MAX_LAG + 1),
  localparam int K_W     = $clog2(K_MAX + 1),
  localparam int PROD_W  = 2 * SAMPLE_W,
  localparam int RES_W   = PROD_W
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic                       mode,
  input  logic [LAG_W-1:0]           lag,
  input  logic [K_W-1:0]             win_log,
  input  logic [LFSR_W-1:0]          seed,
  output logic signed [SAMPLE_W-1:0] stim_out,
  input  logic signed [SAMPLE_W-1:0] samp_in,
  input  logic                       samp_valid,
  output logic                       busy,
  output logic                       done,
  output logic signed [RES_W-1:0]    result
);
  localparam int ACC_W = PROD_W + K_MAX + 1;
  localparam int CNT_W = K_MAX + 1;
  localparam logic signed [SAMPLE_W-1:0] FULL_POS = SAMPLE_W'((1 << (SAMPLE_W-1)) - 1);
  localparam logic signed [SAMPLE_W-1:0] FULL_NEG = -FULL_POS;

  function automatic logic signed [SAMPLE_W-1:0] bit_level(input logic b);
    return b ? FULL_POS : FULL_NEG;
  endfunction

  function automatic logic signed [PROD_W-1:0] corr_term(
    input logic auto_m, input logic signed [SAMPLE_W-1:0] y,
    input logic signed [SAMPLE_W-1:0] xl, input logic use_x);
    logic signed [PROD_W-1:0] ye, xe;
    ye = PROD_W'(y);
    xe = PROD_W'(xl);
    if (auto_m)     return ye * ye;
    else if (use_x) return ye * xe;
    else            return '0;
  endfunction

  corr_mode_e           mode_q;
  logic [LAG_W-1:0]     lag_q;
  logic [K_W-1:0]       k_q;
  logic                 busy_q, done_q;
  logic                 accept, win_end, x_now, x_lag, lag_ok;
  logic [CNT_W-1:0]     cnt;
  logic signed [PROD_W-1:0] prod;

  assign accept = busy_q && samp_valid && !start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      mode_q <= MODE_CROSS;
      lag_q  <= '0;
      k_q    <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      done_q <= 1'b0;
      mode_q <= corr_mode_e'(mode);
      lag_q  <= lag;
      k_q    <= win_log;
    end else if (win_end) begin
      busy_q <= 1'b0;
      done_q <= 1'b1;
    end
  end

  prc_lfsr u_lfsr (
    .clk(clk), .rst_n(rst_n), .load(start), .advance(accept),
    .seed(seed), .bit_o(x_now)
  );

  prc_lagline #(.DEPTH(MAX_LAG), .SEL_W(LAG_W)) u_lag (
    .clk(clk), .rst_n(rst_n), .clear(start), .shift(accept),
    .din(x_now), .sel(lag_q), .tap(x_lag)
  );

  assign lag_ok = cnt >= CNT_W'(lag_q);
  assign prod   = corr_term(mode_q == MODE_AUTO, samp_in, bit_level(x_lag), lag_ok);

  prc_mac #(.PROD_W(PROD_W), .ACC_W(ACC_W), .RES_W(RES_W), .K_W(K_W), .CNT_W(CNT_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .clear(start), .accept(accept), .prod(prod),
    .k(k_q), .cnt(cnt), .win_end(win_end), .result(result)
  );

  assign stim_out = bit_level(x_now);
  assign busy     = busy_q;
  assign done     = done_q;

  // R8: busy and done are never high together
  a_r8_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
  // R8: done follows the last accepted sample
  a_r8_done_rise: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |=> done_q && !busy_q);
  // R9: start re-arms the block
  a_r9_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy_q && !done_q);
  // R3: stimulus is always one of the two full-scale levels
  a_r3_stim_levels: assert property (@(posedge clk) disable iff (!rst_n)
    (stim_out == FULL_POS) || (stim_out == FULL_NEG));
endmodule

// File: tb/prcorr_analyzer_bench.sv
module prcorr_analyzer_bench;
  localparam int FS = 2047;
  localparam int NV = 8;
  // columns: mode, lag, k, seed, pattern, parameter, gaps
  localparam int VEC [NV][7] = '{
    '{0,  0, 6, 'hACE1, 0,   0, 0},
    '{0,  5, 7, 'h1234, 0,   5, 1},
    '{0,  3, 6, 'hBEEF, 0,   5, 0},
    '{1,  0, 5, 'h0001, 1, -700, 0},
    '{1,  9, 4, 'h5A5A, 2,   0, 1},
    '{0, 63, 7, 'h8001, 0,  63, 0},
    '{0,  2, 0, 'h00FF, 1, 1000, 0},
    '{0,  0, 0, 'h0000, 1, 1000, 0}
  };

  logic clk = 1'b0;
  logic rst_n, start, mode, samp_valid, busy, done;
  logic [5:0] lag;
  logic [3:0] win_log;
  logic [15:0] seed;
  logic signed [11:0] stim_out, samp_in;
  logic signed [23:0] result;

  int checks = 0, errors = 0;
  int xb [0:1023];
  bit [15:0] mst;

  always #10 clk = ~clk;

  prcorr_analyzer u_prcorr_analyzer (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .lag(lag),
    .win_log(win_log), .seed(seed), .stim_out(stim_out), .samp_in(samp_in),
    .samp_valid(samp_valid), .busy(busy), .done(done), .result(result)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int lev(input int b);
    return b ? FS : -FS;
  endfunction

  function automatic bit [15:0] mstep(input bit [15:0] s);
    bit fb;
    fb = s[0];
    s = {fb, s[15:1]};
    s[13] ^= fb; s[12] ^= fb; s[10] ^= fb;
    return s;
  endfunction

  function automatic int resp(input int pat, input int par, input int n);
    if (pat == 0) return (n >= par) ? lev(xb[n-par]) / 2 : 0;
    if (pat == 1) return par;
    return ((n * 37) % 512) - 256;
  endfunction

  task automatic run_window(input int md, input int lg, input int k, input int sd,
                            input int pat, input int par, input int gap,
                            output longint expv, output int stim_bad);
    longint sum = 0;
    int n, y;
    @(negedge clk);
    start = 1; mode = md[0]; lag = lg[5:0]; win_log = k[3:0]; seed = sd[15:0];
    samp_valid = 0;
    @(negedge clk);
    start = 0;
    check(!done && busy, "R9", "armed after start (done,busy)", {done, busy}, 1);
    mst = (sd[15:0] == 0) ? 16'h0001 : sd[15:0];
    n = 1 << k;
    stim_bad = 0;
    for (int i = 0; i < n; i++) begin
      if (gap != 0 && (i % 3) == 1) begin
        samp_valid = 0; samp_in = 12'sd999;
        @(negedge clk);
      end
      xb[i] = mst[0];
      if (int'(stim_out) != lev(xb[i])) stim_bad++;
      y = resp(pat, par, i);
      samp_in = y[11:0]; samp_valid = 1;
      if (md != 0) sum += longint'(y) * y;
      else if (i >= lg) sum += longint'(lev(xb[i-lg])) * y;
      mst = mstep(mst);
      @(negedge clk);
    end
    samp_valid = 0;
    expv = sum >>> k;
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    longint ev, held;
    int bad;
    logic signed [11:0] s_hold;
    rst_n = 0; start = 0; mode = 0; lag = 0; win_log = 0; seed = 0;
    samp_in = 0; samp_valid = 0;
    repeat (3) @(negedge clk);
    check(!done && !busy, "R1", "reset done/busy", {done, busy}, 0);
    check(result == 0, "R1", "reset result", result, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      run_window(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5],
                 VEC[v][6], ev, bad);
      check(done && !busy, "R8", "done after window", {done, busy}, 2);
      check(longint'(result) == ev, VEC[v][0] ? "R5 R6 R7" : "R4 R6 R7",
            $sformatf("vector %0d result", v), result, ev);
      check(bad == 0, "R2 R3", $sformatf("vector %0d stimulus mismatches", v), bad, 0);
    end

    // R8 and R7: samples while done are ignored
    held = result; s_hold = stim_out;
    for (int i = 0; i < 5; i++) begin
      samp_in = 12'sd1500; samp_valid = 1;
      @(negedge clk);
    end
    samp_valid = 0;
    @(negedge clk);
    check(longint'(result) == held, "R8", "result held while done", result, held);
    check(done && !busy, "R8", "done held while idle", {done, busy}, 2);
    check(stim_out == s_hold, "R7", "stimulus frozen while idle", stim_out, s_hold);

    // R9: restart in the middle of a window gives a clean result
    @(negedge clk);
    start = 1; mode = 1; lag = 0; win_log = 6; seed = 16'h0F0F;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < 10; i++) begin
      samp_in = 12'sd2000; samp_valid = 1;
      @(negedge clk);
    end
    samp_valid = 1;
    run_window(0, 5, 7, 'h1234, 0, 5, 1, ev, bad);
    check(longint'(result) == ev, "R9", "restart mid-window result", result, ev);
    check(bad == 0, "R9", "restart reloads seed", bad, 0);

    // R6: smallest window, auto mode with negative sample
    run_window(1, 0, 0, 'h0001, 1, -3, 0, ev, bad);
    check(longint'(result) == 9, "R6", "one-sample auto window", result, 9);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule